// File: doc/BRIEF.md
# Diode Switch Matrix Scanner

This block reads a front-panel keypad wired as a diode-isolated grid of row lines and column lines. It pulls one row line low at a time and leaves the others high. It waits a fixed settle time, then reads the column lines one per cycle. A low column means the switch at that crossing is closed. When every row has been visited, the block publishes the whole picture at once as a bitmap and raises a strobe for a single cycle. Scanning then starts again from the first row and never stops.

Some crossings of the grid carry no switch. A parameter mask marks them, and those bitmap bits always read zero, whatever the column line shows. The column lines are active-low with pull-ups. An optional chain of synchronizer flops sits in front of the sampling logic, chosen by a parameter.

In the first clock cycle after reset, the block also reads a two-wire strap, as it would on a jumper header. From the strap it fixes one of three operating modes: calibration allowed, calibration locked out, or an unattended diagnostic cycling mode. The mode then holds until the next reset, whatever the strap does afterwards.

Top module: `keymat_scanner`

## Requirements
- R1: While reset is asserted, every row output is high, the bitmap is all zeros, the strobe is low and mode_valid is low.
- R2: At most one row output is low in any cycle, and once scanning has started exactly one is low.
- R3: Row 0 goes low in the first cycle after reset is released. Each row stays low for SETTLE_CYC+N_COLS cycles, and rows are visited in ascending order, wrapping from the last row back to row 0.
- R4: Bitmap bit r*N_COLS+c is 1 when column c was low while row r was driven. The column is read after the row's settle time, one column per cycle in ascending order, through SYNC_STAGES synchronizer flops.
- R5: The bitmap changes only in the cycle in which scan_done is high. scan_done is high for exactly one cycle. It first rises 1+N_ROWS*(SETTLE_CYC+N_COLS) clock edges after reset release, and then once every N_ROWS*(SETTLE_CYC+N_COLS) cycles.
- R6: A bitmap bit whose PRESENT_MASK bit is 0 always reads 0, even when its column line is pulled low.
- R7: At the first clock edge after reset release, mode_valid becomes 1 and mode is latched from the strap. The encoding is: nocal_n low gives 1 (locked, including the case where both wires are low); otherwise cal_n low gives 0 (calibration allowed); neither wire low gives 2 (diagnostic cycling).
- R8: After mode_valid is set, changes on cal_n and nocal_n do not alter mode until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_n | input | N_COLS | Column lines, active-low, pulled up |
| cal_n | input | 1 | Strap wire: low permits calibration |
| nocal_n | input | 1 | Strap wire: low forbids calibration |
| row_n | output | N_ROWS | Row drive, one line low at a time |
| sw_state | output | N_ROWS*N_COLS | Closed-switch bitmap, bit r*N_COLS+c |
| scan_done | output | 1 | One-cycle strobe when a full scan is published |
| mode | output | 2 | Latched strap mode (0 allowed, 1 locked, 2 diagnostic) |
| mode_valid | output | 1 | Mode has been latched since reset |

## Verification
The strap mode is due one edge after reset release, so the bench samples it at the falling edge that follows. The first row is due at that same falling edge. A running monitor, indexed by the count of rising edges since release, predicts which row is low and which cycles carry scan_done. It checks both against the arithmetic period SETTLE_CYC+N_COLS at every falling edge. Switch patterns are changed at the falling edge just after a strobe, which comes at least SETTLE_CYC edges before the next column read. Each bitmap is compared at the falling edge of its own strobe, against the pattern ANDed with the presence mask.

// File: rtl/keymat_pkg.sv
package keymat_pkg;

   typedef enum logic [1:0] {
      MODE_CAL_OPEN   = 2'd0,
      MODE_CAL_LOCKED = 2'd1,
      MODE_DIAG_CYCLE = 2'd2
   } strap_mode_e;

   typedef enum logic {
      PH_SETTLE = 1'b0,
      PH_SAMPLE = 1'b1
   } scan_phase_e;

   function automatic int unsigned idx_width(input int unsigned count);
      return (count <= 1) ? 1 : $clog2(count);
   endfunction

   function automatic strap_mode_e strap_decode(input logic cal_n, input logic nocal_n);
      if (!nocal_n)    return MODE_CAL_LOCKED;
      else if (!cal_n) return MODE_CAL_OPEN;
      else             return MODE_DIAG_CYCLE;
   endfunction

endpackage

// File: rtl/keymat_col_sync.sv
module keymat_col_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign d_out = d_in;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
            end else begin
               stage_q[0] <= d_in;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign d_out = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/keymat_sequencer.sv
module keymat_sequencer
   import keymat_pkg::*;
#(
   parameter int unsigned N_ROWS     = 10,
   parameter int unsigned N_COLS     = 5,
   parameter int unsigned SETTLE_CYC = 16,
   localparam int unsigned ROW_W     = idx_width(N_ROWS),
   localparam int unsigned COL_W     = idx_width(N_COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [N_ROWS-1:0] row_n,
   output logic              smp_en,
   output logic [ROW_W-1:0]  smp_row,
   output logic [COL_W-1:0]  smp_col,
   output logic              scan_last
);

   localparam int unsigned CNT_W = idx_width(SETTLE_CYC);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(N_ROWS - 1);
   localparam logic [COL_W-1:0] COL_LAST = COL_W'(N_COLS - 1);

   logic                run_q;
   scan_phase_e         phase_q;
   logic [ROW_W-1:0]    row_q;
   logic [COL_W-1:0]    col_q;
   logic [CNT_W-1:0]    cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         phase_q <= PH_SETTLE;
         row_q   <= '0;
         col_q   <= '0;
         cnt_q   <= '0;
      end else begin
         run_q <= 1'b1;
         if (run_q) begin
            case (phase_q)
               PH_SETTLE: begin
                  if (cnt_q == CNT_LAST) begin
                     cnt_q   <= '0;
                     phase_q <= PH_SAMPLE;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
               default: begin
                  if (col_q == COL_LAST) begin
                     col_q   <= '0;
                     phase_q <= PH_SETTLE;
                     row_q   <= (row_q == ROW_LAST) ? '0 : row_q + ROW_W'(1);
                  end else begin
                     col_q <= col_q + COL_W'(1);
                  end
               end
            endcase
         end
      end
   end

   always_comb begin
      for (int r = 0; r < N_ROWS; r++) begin
         row_n[r] = !(run_q && (row_q == ROW_W'(r)));
      end
   end

   assign smp_en    = run_q && (phase_q == PH_SAMPLE);
   assign smp_row   = row_q;
   assign smp_col   = col_q;
   assign scan_last = smp_en && (row_q == ROW_LAST) && (col_q == COL_LAST);

   // R2
   one_row_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~row_n) <= 1);

   // R3
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_en && (col_q == COL_LAST) && (row_q != ROW_LAST)) |=> (row_q == $past(row_q) + ROW_W'(1)));

   // R3
   row_change_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row_n) |-> !smp_en);

   // R4
   sample_row_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_en |-> !row_n[smp_row]);

endmodule

// File: rtl/keymat_collector.sv
module keymat_collector
   import keymat_pkg::*;
#(
   parameter int unsigned N_ROWS = 10,
   parameter int unsigned N_COLS = 5,
   parameter logic [N_ROWS*N_COLS-1:0] PRESENT_MASK = '1,
   localparam int unsigned ROW_W = idx_width(N_ROWS),
   localparam int unsigned COL_W = idx_width(N_COLS),
   localparam int unsigned NBITS = N_ROWS * N_COLS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_COLS-1:0] col_s,
   input  logic              smp_en,
   input  logic [ROW_W-1:0]  smp_row,
   input  logic [COL_W-1:0]  smp_col,
   input  logic              scan_last,
   output logic [NBITS-1:0]  sw_state,
   output logic              scan_done
);

   logic [NBITS-1:0] shadow_q;
   logic [NBITS-1:0] hit_vec;
   logic [NBITS-1:0] state_q;
   logic             done_q;

   always_comb begin
      hit_vec = shadow_q;
      for (int r = 0; r < N_ROWS; r++) begin
         for (int c = 0; c < N_COLS; c++) begin
            if (smp_en && (smp_row == ROW_W'(r)) && (smp_col == COL_W'(c))) begin
               hit_vec[r*N_COLS + c] = PRESENT_MASK[r*N_COLS + c] & ~col_s[c];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         state_q  <= '0;
         done_q   <= 1'b0;
      end else begin
         shadow_q <= hit_vec;
         done_q   <= scan_last;
         if (scan_last) state_q <= hit_vec;
      end
   end

   assign sw_state  = state_q;
   assign scan_done = done_q;

   // R5
   state_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sw_state) |-> scan_done);

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |=> !scan_done);

   // R6
   absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_state & ~PRESENT_MASK) == '0);

endmodule

// File: rtl/keymat_strap_decode.sv
module keymat_strap_decode
   import keymat_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cal_n,
   input  logic        nocal_n,
   output strap_mode_e mode,
   output logic        mode_valid
);

   strap_mode_e mode_q;
   logic        valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_DIAG_CYCLE;
         valid_q <= 1'b0;
      end else if (!valid_q) begin
         mode_q  <= strap_decode(cal_n, nocal_n);
         valid_q <= 1'b1;
      end
   end

   assign mode       = mode_q;
   assign mode_valid = valid_q;

   // R7
   strap_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_valid) |-> ((mode == MODE_CAL_LOCKED) == !$past(nocal_n)));

   // R8
   mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_valid |=> (mode_valid && $stable(mode)));

endmodule

// File: rtl/keymat_scanner.sv
module keymat_scanner
   import keymat_pkg::*;
#(
   parameter int unsigned N_ROWS      = 10,
   parameter int unsigned N_COLS      = 5,
   parameter int unsigned SETTLE_CYC  = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [N_ROWS*N_COLS-1:0] PRESENT_MASK = '1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_COLS-1:0]        col_n,
   input  logic                     cal_n,
   input  logic                     nocal_n,
   output logic [N_ROWS-1:0]        row_n,
   output logic [N_ROWS*N_COLS-1:0] sw_state,
   output logic                     scan_done,
   output logic [1:0]               mode,
   output logic                     mode_valid
);

   localparam int unsigned ROW_W = idx_width(N_ROWS);
   localparam int unsigned COL_W = idx_width(N_COLS);

   generate
      if (N_ROWS < 2) begin : g_bad_rows
         $error("keymat_scanner: N_ROWS must be at least 2");
      end
      if (N_COLS < 2) begin : g_bad_cols
         $error("keymat_scanner: N_COLS must be at least 2");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("keymat_scanner: SETTLE_CYC must be at least 1");
      end
      if (SETTLE_CYC < SYNC_STAGES) begin : g_bad_sync
         $error("keymat_scanner: SETTLE_CYC must cover the synchronizer depth");
      end
      if (N_ROWS * N_COLS > 4096) begin : g_bad_size
         $error("keymat_scanner: matrix too large");
      end
   endgenerate

   logic [N_COLS-1:0] col_s;
   logic              smp_en;
   logic [ROW_W-1:0]  smp_row;
   logic [COL_W-1:0]  smp_col;
   logic              scan_last;
   strap_mode_e       mode_e;

   keymat_col_sync #(
      .WIDTH  (N_COLS),
      .STAGES (SYNC_STAGES)
   ) col_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (col_n),
      .d_out (col_s)
   );

   keymat_sequencer #(
      .N_ROWS     (N_ROWS),
      .N_COLS     (N_COLS),
      .SETTLE_CYC (SETTLE_CYC)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .row_n     (row_n),
      .smp_en    (smp_en),
      .smp_row   (smp_row),
      .smp_col   (smp_col),
      .scan_last (scan_last)
   );

   keymat_collector #(
      .N_ROWS       (N_ROWS),
      .N_COLS       (N_COLS),
      .PRESENT_MASK (PRESENT_MASK)
   ) coll_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .col_s     (col_s),
      .smp_en    (smp_en),
      .smp_row   (smp_row),
      .smp_col   (smp_col),
      .scan_last (scan_last),
      .sw_state  (sw_state),
      .scan_done (scan_done)
   );

   keymat_strap_decode strap_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cal_n      (cal_n),
      .nocal_n    (nocal_n),
      .mode       (mode_e),
      .mode_valid (mode_valid)
   );

   assign mode = mode_e;

endmodule

// File: tb/keymat_scanner_tb_top.sv
`timescale 1ns/1ps
module keymat_scanner_tb_top;

   localparam int unsigned ROWS   = 10;
   localparam int unsigned COLS   = 5;
   localparam int unsigned SETTLE = 3;
   localparam int unsigned SYNC   = 2;
   localparam int unsigned NB     = ROWS * COLS;
   localparam int unsigned PER    = SETTLE + COLS;
   localparam int unsigned SCAN   = ROWS * PER;
   localparam logic [NB-1:0] MASK = ~(NB'(5'h1F) << 20);
   localparam int NPAT = 58;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [COLS-1:0] col_n;
   logic            cal_n, nocal_n;
   logic [ROWS-1:0] row_n;
   logic [NB-1:0]   sw_state;
   logic            scan_done;
   logic [1:0]      mode;
   logic            mode_valid;
   logic [NB-1:0]   pat;

   int n_chk = 0;
   int n_bad = 0;
   int r2_err = 0, r3_err = 0, r5_err = 0;
   int unsigned t;
   logic [NB-1:0] prev_sw;

   always #5 clk = ~clk;

   keymat_scanner #(
      .N_ROWS       (ROWS),
      .N_COLS       (COLS),
      .SETTLE_CYC   (SETTLE),
      .SYNC_STAGES  (SYNC),
      .PRESENT_MASK (MASK)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .col_n      (col_n),
      .cal_n      (cal_n),
      .nocal_n    (nocal_n),
      .row_n      (row_n),
      .sw_state   (sw_state),
      .scan_done  (scan_done),
      .mode       (mode),
      .mode_valid (mode_valid)
   );

   // Diode matrix model: a pressed switch pulls its column low while its row is low.
   always_comb begin
      col_n = '1;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            if (!row_n[r] && pat[r*COLS + c]) col_n[c] = 1'b0;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) t <= 0;
      else        t <= t + 1;
   end

   // Running monitor for R2, R3, R5, indexed by rising edges since release.
   always @(negedge clk) begin
      if (rst_n && t >= 1) begin
         automatic int unsigned   er = ((t - 1) / PER) % ROWS;
         automatic logic [ROWS-1:0] exp_rn = ~(ROWS'(1) << er);
         automatic logic            exp_dn = (t > 1) && (((t - 1) % SCAN) == 0);
         if (row_n != exp_rn) begin
            if (r3_err == 0) $display("mismatch R3 t=%0d row_n=%h exp=%h", t, row_n, exp_rn);
            r3_err++;
         end
         if ($countones(~row_n) != 1) r2_err++;
         if (scan_done != exp_dn) begin
            if (r5_err == 0) $display("mismatch R5 t=%0d done=%b exp=%b", t, scan_done, exp_dn);
            r5_err++;
         end
         if (!scan_done && sw_state != prev_sw) r5_err++;
      end
      prev_sw <= sw_state;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   function automatic logic [NB-1:0] pattern(input int i);
      logic [63:0] h;
      if (i == 0) return '0;
      if (i == 1) return '1;
      if (i == 2) return {25{2'b10}};
      if (i == 3) return {25{2'b01}};
      if (i < 4 + int'(NB)) return NB'(1) << (i - 4);
      h = 64'(i) * 64'h9E3779B97F4A7C15;
      return h[NB-1:0];
   endfunction

   function automatic logic [1:0] exp_mode(input logic c, input logic nc);
      if (!nc)     return 2'd1;
      else if (!c) return 2'd0;
      else         return 2'd2;
   endfunction

   task automatic wait_done();
      @(negedge clk);
      while (!scan_done) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      report();
   end

   initial begin
      rst_n = 1'b0; cal_n = 1'b0; nocal_n = 1'b1; pat = pattern(0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(row_n == '1, "R1", "row_n in reset", 64'(row_n), 64'h3FF);
      check(sw_state == '0, "R1", "sw_state in reset", 64'(sw_state), 0);
      check(scan_done == 1'b0, "R1", "scan_done in reset", 64'(scan_done), 0);
      check(mode_valid == 1'b0, "R1", "mode_valid in reset", 64'(mode_valid), 0);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R7 latched one edge after release; R3 row 0 low at that point
      check(mode_valid && mode == 2'd0, "R7", "cal allowed strap", 64'({mode_valid, mode}), 64'({1'b1, 2'd0}));
      check(row_n == ~ROWS'(1), "R3", "first row low", 64'(row_n), 64'(~ROWS'(1)));

      for (int i = 0; i < NPAT; i++) begin
         wait_done();
         check((sw_state & MASK) == (pattern(i) & MASK), "R4", $sformatf("bitmap pattern %0d", i),
               64'(sw_state & MASK), 64'(pattern(i) & MASK));
         check((sw_state & ~MASK) == '0, "R6", $sformatf("absent bits pattern %0d", i),
               64'(sw_state & ~MASK), 0);
         #1 pat = pattern(i + 1);
      end

      for (int j = 0; j < 4; j++) begin
         automatic logic jc  = (j == 1 || j == 2);
         automatic logic jnc = (j != 0 && j != 1) ? 1'b1 : 1'b0;
         automatic logic [1:0] em;
         if (j == 0) begin jc = 1'b1; jnc = 1'b0; end
         if (j == 1) begin jc = 1'b0; jnc = 1'b0; end
         if (j == 2) begin jc = 1'b1; jnc = 1'b1; end
         if (j == 3) begin jc = 1'b0; jnc = 1'b1; end
         em = exp_mode(jc, jnc);
         @(negedge clk);
         #1 rst_n = 1'b0; cal_n = jc; nocal_n = jnc;
         repeat (2) @(negedge clk);
         #1 rst_n = 1'b1;
         @(negedge clk);
         // R7
         check(mode_valid && mode == em, "R7", $sformatf("strap cal_n=%b nocal_n=%b", jc, jnc),
               64'({mode_valid, mode}), 64'({1'b1, em}));
         for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #1 cal_n = k[0]; nocal_n = k[1];
            repeat (5) @(negedge clk);
         end
         // R8
         check(mode == em, "R8", "mode after strap changes", 64'(mode), 64'(em));
      end

      repeat (SCAN + 5) @(negedge clk);
      check(r2_err == 0, "R2", "cycles with wrong low-row count", 64'(r2_err), 0);
      check(r3_err == 0, "R3", "row sequence mismatches", 64'(r3_err), 0);
      check(r5_err == 0, "R5", "strobe or atomic-update mismatches", 64'(r5_err), 0);
      report();
   end

endmodule